// File: doc/BRIEF.md
# Flash Erase-All Sequencer

This block controls a modelled non-volatile word store split into three regions: main code, user configuration and factory data. A processor talks to it through a small register bus. The bus carries a status word, a mode register that grants programming or erase rights, and trigger registers. When erase rights are granted, a trigger starts a sweep that writes the erased value (all ones) into every word of the code and user configuration regions. One variant of the trigger clears only the user configuration region. The factory region is fixed at reset and can never be changed.

While a sweep runs, the block raises a stall line that holds the processor for a fixed number of clock cycles, set by a parameter. The sweep clears one word per cycle from the first cycle of the stall. The bus never back-pressures: `req_ready` is always high, so every beat with `req_valid` high is taken. Each accepted read answers with `rsp_valid` and `rsp_rdata` on the following cycle. A separate word port allows programming and inspection of the store. Its read is combinational and its write takes effect at the next clock edge.

Top module: `fw_wipe_top`

## Requirements
- R1: After reset the status word reads 1, the mode register reads 0, `stall` is low, every code and user configuration word reads 32'hFFFF_FFFF, and factory word k (at flat index CODE_WORDS+UCFG_WORDS+k) reads 32'h5A00_0000 | k.
- R2: `req_ready` is always 1. A read accepted at one edge drives `rsp_valid` high with its data for exactly the next cycle. The byte offsets are: status 0x400 (bit 0), mode 0x504 (bits 1:0), page stub 0x508, full wipe 0x50C, config wipe 0x514. Trigger offsets and unmapped offsets read 0.
- R3: The mode values are 0 = read-only, 1 = program-enable, 2 = erase-enable, and 3 behaves as read-only. A word-port write changes the store only when the mode is 1, no sweep is running and the index is inside the code or user configuration region.
- R4: A write with wdata bit 0 = 1 to 0x50C starts a full wipe only when the mode is 2 and no sweep is running. Any other such write has no effect.
- R5: A full wipe sets every code and user configuration word to 32'hFFFF_FFFF.
- R6: Factory words never change, whether through a wipe or a word-port write.
- R7: `stall` rises at the edge that accepts a starting trigger and stays high for exactly ERASE_ALL_CYCLES cycles (at least CODE_WORDS+UCFG_WORDS). The status word reads 0 while `stall` is high.
- R8: A trigger written while a sweep is running is ignored and does not lengthen the stall.
- R9: A write with bit 0 = 1 to 0x514, in mode 2 with no sweep running, sets only the user configuration words to all ones. It stalls for UCFG_ERASE_CYCLES cycles and leaves the code words untouched.
- R10: A write to 0x508 leaves the store unchanged and does not raise `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| stall | output | 1 | Processor hold during a sweep |
| arr_we | input | 1 | Word-port write strobe |
| arr_addr | input | AW | Word-port flat index |
| arr_wdata | input | 32 | Word-port write data |
| arr_rdata | output | 32 | Word-port read data (combinational) |

## Verification
The bench builds the block with 32 code words, 4 user configuration words, 4 factory words, a 50-cycle full wipe and a 9-cycle configuration wipe. These small regions let every word be compared after each sweep. The short durations let the bench count each stall cycle by cycle. They also leave room inside a single stall to retrigger both wipes, to flip the mode and to attempt a programming write. Random programming under random modes, mixed with random triggers, walks through every mode value against every region.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    MODE_RO  = 2'd0,
    MODE_PRG = 2'd1,
    MODE_ERS = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  localparam logic [11:0] OFS_STATUS = 12'h400;
  localparam logic [11:0] OFS_MODE   = 12'h504;
  localparam logic [11:0] OFS_PAGE   = 12'h508;
  localparam logic [11:0] OFS_FULL   = 12'h50C;
  localparam logic [11:0] OFS_UWIPE  = 12'h514;

  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

  // Fixed content of factory word k.
  function automatic logic [31:0] factory_word(input int unsigned k);
    logic [31:0] kw;
    kw = k;
    return 32'h5A00_0000 | {8'h00, kw[23:0]};
  endfunction

endpackage

// File: rtl/fw_regs.sv
module fw_regs
  import fw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        busy,
  output mode_e       mode,
  output logic        start_full,
  output logic        start_uwipe
);

  logic        acc;
  logic        wr_acc;
  logic        erase_ok;
  logic [31:0] rd_mux;
  mode_e       mode_q;
  logic        unused_wdata;

  assign req_ready    = 1'b1;
  assign acc          = req_valid & req_ready;
  assign wr_acc       = acc & req_write;
  assign erase_ok     = (mode_q == MODE_ERS) & ~busy & req_wdata[0];
  assign start_full   = wr_acc & (req_addr == OFS_FULL) & erase_ok;
  assign start_uwipe  = wr_acc & (req_addr == OFS_UWIPE) & erase_ok;
  assign mode         = mode_q;
  assign unused_wdata = ^req_wdata[31:2];

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFS_STATUS: rd_mux = {31'd0, ~busy};
      OFS_MODE:   rd_mux = {30'd0, mode_q};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_RO;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (wr_acc && req_addr == OFS_MODE) begin
        mode_q <= mode_e'(req_wdata[1:0]);
      end
      rsp_valid <= acc & ~req_write;
      if (acc && !req_write) begin
        rsp_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/fw_seq.sv
module fw_seq #(
  parameter int CODE_WORDS = 64,
  parameter int UCFG_WORDS = 8,
  parameter int DUR_FULL   = 100,
  parameter int DUR_UWIPE  = 20,
  parameter int AW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_full,
  input  logic          start_uwipe,
  output logic          busy,
  output logic          clr_en,
  output logic [AW-1:0] clr_idx
);

  localparam int DMAX = (DUR_FULL > DUR_UWIPE) ? DUR_FULL : DUR_UWIPE;
  localparam int CW   = $clog2(DMAX + 1);

  localparam logic [CW-1:0] LAST_FULL  = CW'(DUR_FULL - 1);
  localparam logic [CW-1:0] LAST_UWIPE = CW'(DUR_UWIPE - 1);
  localparam logic [CW-1:0] SPAN_FULL  = CW'(CODE_WORDS + UCFG_WORDS);
  localparam logic [CW-1:0] SPAN_UWIPE = CW'(UCFG_WORDS);
  localparam logic [CW-1:0] BASE_UWIPE = CW'(CODE_WORDS);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;
  logic [CW-1:0] base_q;
  logic [CW-1:0] span_q;
  logic [CW-1:0] sum;

  assign busy    = busy_q;
  assign clr_en  = busy_q & (cnt_q < span_q);
  assign sum     = base_q + cnt_q;
  assign clr_idx = AW'(sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      base_q <= '0;
      span_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == last_q) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_full) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      last_q <= LAST_FULL;
      base_q <= '0;
      span_q <= SPAN_FULL;
    end else if (start_uwipe) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      last_q <= LAST_UWIPE;
      base_q <= BASE_UWIPE;
      span_q <= SPAN_UWIPE;
    end
  end

endmodule

// File: rtl/fw_store.sv
module fw_store
  import fw_pkg::*;
#(
  parameter int CODE_WORDS = 64,
  parameter int UCFG_WORDS = 8,
  parameter int FACT_WORDS = 8,
  parameter int AW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_idx,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);

  localparam int USER_WORDS = CODE_WORDS + UCFG_WORDS;
  localparam int TOTAL      = USER_WORDS + FACT_WORDS;

  logic [31:0] words [TOTAL];

  for (genvar g = 0; g < TOTAL; g++) begin : g_word
    if (g < USER_WORDS) begin : g_user
      localparam logic [AW-1:0] IDX = AW'(g);
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          word_q <= ERASED_WORD;
        end else if (clr_en && clr_idx == IDX) begin
          word_q <= ERASED_WORD;
        end else if (wr_en && wr_idx == IDX) begin
          word_q <= wr_data;
        end
      end
      assign words[g] = word_q;
    end else begin : g_fact
      assign words[g] = factory_word(g - USER_WORDS);
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < TOTAL) begin
      rd_data = words[rd_idx];
    end
  end

endmodule

// File: rtl/fw_wipe_top.sv
module fw_wipe_top
  import fw_pkg::*;
#(
  parameter int CODE_WORDS        = 64,
  parameter int UCFG_WORDS        = 8,
  parameter int FACT_WORDS        = 8,
  parameter int ERASE_ALL_CYCLES  = 100,
  parameter int UCFG_ERASE_CYCLES = 20,
  localparam int TOTAL = CODE_WORDS + UCFG_WORDS + FACT_WORDS,
  localparam int AW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [11:0]   req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          stall,
  input  logic          arr_we,
  input  logic [AW-1:0] arr_addr,
  input  logic [31:0]   arr_wdata,
  output logic [31:0]   arr_rdata
);

  localparam int USER_WORDS = CODE_WORDS + UCFG_WORDS;
  localparam int DUR_FULL   = (ERASE_ALL_CYCLES > USER_WORDS) ? ERASE_ALL_CYCLES : USER_WORDS;
  localparam int DUR_UWIPE  = (UCFG_ERASE_CYCLES > UCFG_WORDS) ? UCFG_ERASE_CYCLES : UCFG_WORDS;

  mode_e         mode;
  logic          busy;
  logic          start_full;
  logic          start_uwipe;
  logic          clr_en;
  logic [AW-1:0] clr_idx;
  logic          prog_ok;

  assign stall   = busy;
  assign prog_ok = arr_we & (mode == MODE_PRG) & ~busy & (int'(arr_addr) < USER_WORDS);

  fw_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .busy        (busy),
    .mode        (mode),
    .start_full  (start_full),
    .start_uwipe (start_uwipe)
  );

  fw_seq #(
    .CODE_WORDS (CODE_WORDS),
    .UCFG_WORDS (UCFG_WORDS),
    .DUR_FULL   (DUR_FULL),
    .DUR_UWIPE  (DUR_UWIPE),
    .AW         (AW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_full  (start_full),
    .start_uwipe (start_uwipe),
    .busy        (busy),
    .clr_en      (clr_en),
    .clr_idx     (clr_idx)
  );

  fw_store #(
    .CODE_WORDS (CODE_WORDS),
    .UCFG_WORDS (UCFG_WORDS),
    .FACT_WORDS (FACT_WORDS),
    .AW         (AW)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prog_ok),
    .wr_idx  (arr_addr),
    .wr_data (arr_wdata),
    .clr_en  (clr_en),
    .clr_idx (clr_idx),
    .rd_idx  (arr_addr),
    .rd_data (arr_rdata)
  );

endmodule

// File: rtl/fw_wipe_chk.sv
module fw_wipe_chk
  import fw_pkg::*;
#(
  parameter int USER_WORDS = 72,
  parameter int TOTAL      = 80,
  parameter int DUR_MAX    = 100,
  parameter int AW         = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [11:0]   req_addr,
  input logic [31:0]   req_wdata,
  input logic          rsp_valid,
  input logic          stall,
  input logic [1:0]    mode_bits,
  input logic [AW-1:0] arr_addr,
  input logic [31:0]   arr_rdata
);

  logic        wr_beat;
  logic        rd_beat;
  logic [31:0] stall_run;

  assign wr_beat = req_valid & req_ready & req_write;
  assign rd_beat = req_valid & req_ready & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_run <= '0;
    else if (stall) stall_run <= stall_run + 1;
    else stall_run <= '0;
  end

  // R2: one response beat per accepted read
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_beat |=> !rsp_valid);

  // R4: full wipe without erase rights leaves the stall low
  a_r4_no_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beat && req_addr == OFS_FULL && mode_bits != 2'd2 && !stall) |=> !stall);

  // R7: a permitted full wipe raises the stall at once
  a_r7_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beat && req_addr == OFS_FULL && req_wdata[0] && mode_bits == 2'd2 && !stall) |=> stall);

  // R7 / R8: the stall never outlasts the longest sweep
  a_r7_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (stall_run < DUR_MAX));

  // R6: factory words always read their fixed content
  a_r6_factory_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(arr_addr) >= USER_WORDS && int'(arr_addr) < TOTAL)
      |-> (arr_rdata == factory_word(int'(arr_addr) - USER_WORDS)));

  // R10: the page stub never starts a sweep
  a_r10_page_stub: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_beat && req_addr == OFS_PAGE && !stall) |=> !stall);

endmodule

bind fw_wipe_top fw_wipe_chk #(
  .USER_WORDS (USER_WORDS),
  .TOTAL      (TOTAL),
  .DUR_MAX    ((DUR_FULL > DUR_UWIPE) ? DUR_FULL : DUR_UWIPE),
  .AW         (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .stall     (stall),
  .mode_bits (mode),
  .arr_addr  (arr_addr),
  .arr_rdata (arr_rdata)
);

// File: tb/fw_wipe_top_tb_top.sv
`timescale 1ns/1ps
module fw_wipe_top_tb_top;

  localparam int CODE  = 32;
  localparam int UCFG  = 4;
  localparam int FACT  = 4;
  localparam int DA    = 50;
  localparam int DU    = 9;
  localparam int USER  = CODE + UCFG;
  localparam int TOTAL = USER + FACT;
  localparam int AW    = $clog2(TOTAL);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [11:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          stall;
  logic          arr_we = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [31:0]   arr_wdata = '0;
  logic [31:0]   arr_rdata;

  int checks = 0;
  int errors = 0;
  int stall_cnt = 0;
  logic [1:0]  cur_mode = 2'd0;
  logic [31:0] model [TOTAL];

  always #10 clk = ~clk;

  fw_wipe_top #(
    .CODE_WORDS (CODE), .UCFG_WORDS (UCFG), .FACT_WORDS (FACT),
    .ERASE_ALL_CYCLES (DA), .UCFG_ERASE_CYCLES (DU)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .stall (stall),
    .arr_we (arr_we), .arr_addr (arr_addr), .arr_wdata (arr_wdata), .arr_rdata (arr_rdata)
  );

  always @(negedge clk) if (stall) stall_cnt++;

  function automatic logic [31:0] fact_val(int k);
    logic [31:0] kw;
    kw = k;
    return 32'h5A00_0000 | {8'h00, kw[23:0]};
  endfunction

  function automatic bit prog_allowed(logic [1:0] m, int idx);
    return (m == 2'd1) && (idx < USER);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic arr_wr(int idx, logic [31:0] d);
    arr_we = 1'b1; arr_addr = AW'(idx); arr_wdata = d;
    @(posedge clk); @(negedge clk);
    arr_we = 1'b0;
  endtask

  task automatic arr_rd(int idx, output logic [31:0] d);
    arr_addr = AW'(idx); #1; d = arr_rdata;
  endtask

  task automatic set_mode(logic [1:0] m);
    bus_wr(12'h504, {30'd0, m});
    cur_mode = m;
  endtask

  task automatic prog(int idx, logic [31:0] d);
    if (prog_allowed(cur_mode, idx) && !stall) model[idx] = d;
    arr_wr(idx, d);
  endtask

  task automatic cmp_store(string req);
    logic [31:0] v;
    int bad = 0;
    for (int i = 0; i < TOTAL; i++) begin
      arr_rd(i, v);
      if (v !== model[i]) begin
        bad++;
        $display("FAIL %s: word %0d actual %h expected %h", req, i, v, model[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic wait_idle();
    while (stall) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < TOTAL; i++) model[i] = (i < USER) ? 32'hFFFF_FFFF : fact_val(i - USER);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(12'h400, v); chk("R1 status", v, 32'd1);
    bus_rd(12'h504, v); chk("R1 mode", v, 32'd0);
    chk("R1 stall", {31'd0, stall}, 32'd0);
    cmp_store("R1 store after reset");

    // R2 ready, unmapped and trigger offsets read 0
    chk("R2 req_ready", {31'd0, req_ready}, 32'd1);
    bus_rd(12'h000, v); chk("R2 unmapped", v, 32'd0);
    bus_rd(12'h50C, v); chk("R2 trigger reads 0", v, 32'd0);
    @(negedge clk); chk("R2 rsp one cycle", {31'd0, rsp_valid}, 32'd0);

    // R3 programming only in mode 1
    set_mode(2'd0); prog(3, 32'h1111_0003);
    set_mode(2'd3); prog(4, 32'h1111_0004);
    set_mode(2'd2); prog(5, 32'h1111_0005);
    cmp_store("R3 no program outside mode 1");
    set_mode(2'd1);
    bus_rd(12'h504, v); chk("R3 mode readback", v, 32'd1);
    for (int i = 0; i < USER; i++) prog(i, $urandom());
    prog(USER, 32'h0BAD_0000);  // R6 factory write
    prog(USER + FACT - 1, 32'h0BAD_0001);
    cmp_store("R3 R6 programmed");

    // R4 trigger without erase rights
    bus_wr(12'h50C, 32'd1); chk("R4 mode1 no stall", {31'd0, stall}, 32'd0);
    set_mode(2'd3);
    bus_wr(12'h50C, 32'd1); chk("R4 mode3 no stall", {31'd0, stall}, 32'd0);
    set_mode(2'd2);
    bus_wr(12'h50C, 32'd0); chk("R4 bit0 clear no stall", {31'd0, stall}, 32'd0);
    cmp_store("R4 store untouched");

    // R10 page stub
    bus_wr(12'h508, 32'hFFFF_FFFF); chk("R10 no stall", {31'd0, stall}, 32'd0);
    cmp_store("R10 store untouched");

    // R7 R8 R5 full wipe
    stall_cnt = 0;
    bus_wr(12'h50C, 32'd1);
    chk("R7 stall raised", {31'd0, stall}, 32'd1);
    bus_rd(12'h400, v); chk("R7 status busy", v, 32'd0);
    bus_wr(12'h50C, 32'd1);   // R8 retrigger
    bus_wr(12'h514, 32'd1);   // R8 retrigger config wipe
    set_mode(2'd1);
    repeat (CODE + UCFG) @(negedge clk);
    arr_wr(0, 32'h0000_1234); // R3 ignored while busy
    wait_idle();
    chk("R7 R8 stall length", stall_cnt, DA);
    for (int i = 0; i < USER; i++) model[i] = 32'hFFFF_FFFF;
    cmp_store("R5 R6 after full wipe");
    bus_rd(12'h400, v); chk("R7 status idle", v, 32'd1);

    // R9 config-region wipe
    for (int i = 0; i < USER; i++) prog(i, $urandom());
    set_mode(2'd2);
    stall_cnt = 0;
    bus_wr(12'h514, 32'd1);
    wait_idle();
    chk("R9 stall length", stall_cnt, DU);
    for (int i = CODE; i < USER; i++) model[i] = 32'hFFFF_FFFF;
    cmp_store("R9 only config region");

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom_range(0, 9));
      if (op < 6) begin
        prog(int'($urandom_range(0, TOTAL - 1)), $urandom());
      end else if (op < 8) begin
        set_mode(2'($urandom_range(0, 3)));
      end else begin
        logic [11:0] a = (op == 8) ? 12'h50C : 12'h514;
        logic [31:0] d = $urandom_range(0, 3);
        bit go = (cur_mode == 2'd2) && d[0];
        stall_cnt = 0;
        bus_wr(a, d);
        wait_idle();
        if (go) begin
          for (int i = (op == 8) ? 0 : CODE; i < USER; i++) model[i] = 32'hFFFF_FFFF;
          chk(op == 8 ? "R7 random full length" : "R9 random config length", stall_cnt, op == 8 ? DA : DU);
        end else begin
          chk("R4 random ignored", stall_cnt, 0);
        end
        cmp_store("R5 R9 random store");
      end
    end
    cmp_store("R3 R6 final store");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule